// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block counts clocks to pace one successive-approximation conversion for an analog converter core that sits outside it. When the enable input rises, the sequencer first runs a fixed 64-clock stabilization period. After that it waits for a start trigger. A trigger runs three counted phases, setup, conversion and wait, and then raises a one-cycle end-of-conversion interrupt. The analog core is switched on only during the conversion phase, so it draws no current during the wait phase.

The trigger comes from one of three sources: a software strobe, or one of two hardware inputs (external and timer). A mode bit and a source-select bit choose which source is live. A recognised trigger, or a control-register write strobe, that arrives while a conversion is running aborts that conversion and starts again from setup. If either one lands on the clock where stabilization ends, a full stabilization period is run again. This repeats for as long as the collisions repeat. A 3-bit speed code sets the lengths of the three phases, with totals from 66 to 467 clocks.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While `en` is low, the phase outputs, `conv_en` and `eoc` are all low. Dropping `en` makes all of them low from the next clock, and the interrupt of the aborted conversion is never raised.
- R2: A rising `en` starts a stabilization phase (`ph_stab` high) that lasts exactly 64 clocks. No setup, conversion or wait phase occurs during it.
- R3: For speed code c (0 to 7), the setup phase lasts min(13·(c+1), 50) clocks, the conversion phase 26·(c+1) clocks and the wait phase 26·(c+1)+1 clocks. The totals are 66, 131, 196, 259, 311, 363, 415 and 467 clocks. Setup is always followed by conversion.
- R4: `conv_en` is high exactly in the clocks where `ph_conv` is high. At most one phase output is high at a time.
- R5: `eoc` is a one-clock pulse that is raised in the clock after the last wait-phase clock, and only then.
- R6: A trigger sampled at clock edge k is acted on at edge k+3. For a trigger in the ready state, `eoc` therefore follows edge k+3+total.
- R7: With `hw_mode`=0, only `sw_trig` starts a cycle. With `hw_mode`=1, `sw_trig` is ignored and only the source picked by `src_sel` starts a cycle (0 = `ext_trig`, 1 = `tmr_trig`).
- R8: A `cfg_wr` strobe or a recognised trigger during setup, conversion or wait restarts setup at once, using the speed code applied at that moment. After a `cfg_wr` sampled at edge w, `eoc` follows edge w+total.
- R9: A `cfg_wr` or a recognised trigger at the edge that would end stabilization reloads a full 64-clock stabilization. This happens again at every such collision.
- R10: A trigger recognised during stabilization is held, and setup begins directly after stabilization ends. A trigger in the ready state starts setup with no stabilization.
- R11: A `cfg_wr` strobe in the ready state starts no phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| hw_mode | input | 1 | 0 = software trigger, 1 = hardware trigger |
| src_sel | input | 1 | Hardware source: 0 = external, 1 = timer |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | External trigger strobe |
| tmr_trig | input | 1 | Timer trigger strobe |
| cfg_wr | input | 1 | Control-register write strobe |
| speed | input | 3 | Speed code selecting the phase lengths |
| ph_stab | output | 1 | Stabilization phase active |
| ph_setup | output | 1 | Setup phase active |
| ph_conv | output | 1 | Conversion phase active |
| ph_wait | output | 1 | Wait phase active |
| conv_en | output | 1 | Enable for the analog core |
| eoc | output | 1 | End-of-conversion interrupt pulse |

## Verification
Two functions can fall in the same cycle: the end of stabilization, and the arrival of a control write or a recognised trigger. The bench raises the write strobe so that it is sampled exactly 64 edges after enable, and then again 64 edges later. It expects 192 stabilization clocks and no setup. It also aligns a trigger so that it is recognised on the ending edge. It expects 128 stabilization clocks, after which the held trigger starts setup, and it checks the interrupt edge through the scoreboard.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAB,
    ST_READY,
    ST_SETUP,
    ST_CONV,
    ST_WAIT
  } seq_state_e;

  // setup phase grows with the code until a cap is reached
  function automatic int setup_len(input int code, input int unit, input int cap);
    int v;
    v = unit * (code + 1);
    return (v > cap) ? cap : v;
  endfunction

  function automatic int conv_len(input int code, input int unit);
    return unit * (code + 1);
  endfunction

  // wait phase is one clock longer than the conversion phase
  function automatic int wait_len(input int code, input int unit);
    return unit * (code + 1) + 1;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hw_mode,
  input  logic src_sel,
  input  logic sw_trig,
  input  logic ext_trig,
  input  logic tmr_trig,
  output logic trg_hit
);

  logic raw;
  logic [LAT-1:0] stg;

  always_comb raw = hw_mode ? (src_sel ? tmr_trig : ext_trig) : sw_trig;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || !en) stg <= '0;
        else            stg <= raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || !en) stg <= '0;
        else            stg <= {stg[LAT-2:0], raw};
      end
    end
  endgenerate

  assign trg_hit = stg[LAT-1];

  // R1
  flush_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !trg_hit);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int STAB_CYCLES = 64,
  parameter int SETUP_UNIT  = 13,
  parameter int SETUP_CAP   = 50,
  parameter int CONV_UNIT   = 26,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_wr,
  input  logic              trg_hit,
  input  logic [CODE_W-1:0] speed,
  output logic              ph_stab,
  output logic              ph_setup,
  output logic              ph_conv,
  output logic              ph_wait,
  output logic              conv_en,
  output logic              eoc
);

  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYCLES - 1);

  seq_state_e        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              pend, pend_n;
  logic              eoc_n;
  logic              restart;

  assign restart = cfg_wr || trg_hit;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    code_n = code_q;
    pend_n = pend;
    eoc_n  = 1'b0;
    if (!en) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      pend_n = 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          st_n   = ST_STAB;
          cnt_n  = STAB_LAST;
          pend_n = 1'b0;
        end
        ST_STAB: begin
          if (cnt == '0) begin
            if (restart) begin
              cnt_n  = STAB_LAST;
              pend_n = pend | trg_hit;
            end else if (pend) begin
              st_n   = ST_SETUP;
              cnt_n  = CNT_W'(setup_len(int'(speed), SETUP_UNIT, SETUP_CAP) - 1);
              code_n = speed;
              pend_n = 1'b0;
            end else begin
              st_n = ST_READY;
            end
          end else begin
            cnt_n  = cnt - 1'b1;
            pend_n = pend | trg_hit;
          end
        end
        ST_READY: begin
          if (trg_hit) begin
            st_n   = ST_SETUP;
            cnt_n  = CNT_W'(setup_len(int'(speed), SETUP_UNIT, SETUP_CAP) - 1);
            code_n = speed;
          end
        end
        default: begin
          if (restart) begin
            st_n   = ST_SETUP;
            cnt_n  = CNT_W'(setup_len(int'(speed), SETUP_UNIT, SETUP_CAP) - 1);
            code_n = speed;
          end else if (cnt != '0) begin
            cnt_n = cnt - 1'b1;
          end else begin
            case (st)
              ST_SETUP: begin
                st_n  = ST_CONV;
                cnt_n = CNT_W'(conv_len(int'(code_q), CONV_UNIT) - 1);
              end
              ST_CONV: begin
                st_n  = ST_WAIT;
                cnt_n = CNT_W'(wait_len(int'(code_q), CONV_UNIT) - 1);
              end
              default: begin
                st_n  = ST_READY;
                eoc_n = 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      code_q   <= '0;
      pend     <= 1'b0;
      ph_stab  <= 1'b0;
      ph_setup <= 1'b0;
      ph_conv  <= 1'b0;
      ph_wait  <= 1'b0;
      conv_en  <= 1'b0;
      eoc      <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      code_q   <= code_n;
      pend     <= pend_n;
      ph_stab  <= (st_n == ST_STAB);
      ph_setup <= (st_n == ST_SETUP);
      ph_conv  <= (st_n == ST_CONV);
      ph_wait  <= (st_n == ST_WAIT);
      conv_en  <= (st_n == ST_CONV);
      eoc      <= eoc_n;
    end
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(ph_stab || ph_setup || ph_conv || ph_wait || conv_en || eoc));

  // R2
  stab_after_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> ph_stab);

  // R3
  conv_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_conv) |-> $past(ph_setup));

  // R4
  single_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_stab, ph_setup, ph_conv, ph_wait}));

  // R5
  eoc_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    eoc |-> $past(ph_wait));

  // R5
  eoc_single_chk: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int CODE_W      = 3,
  parameter int STAB_CYCLES = 64,
  parameter int TRIG_LAT    = 3,
  parameter int SETUP_UNIT  = 13,
  parameter int SETUP_CAP   = 50,
  parameter int CONV_UNIT   = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hw_mode,
  input  logic              src_sel,
  input  logic              sw_trig,
  input  logic              ext_trig,
  input  logic              tmr_trig,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] speed,
  output logic              ph_stab,
  output logic              ph_setup,
  output logic              ph_conv,
  output logic              ph_wait,
  output logic              conv_en,
  output logic              eoc
);

  localparam int MAX_PHASE = CONV_UNIT * (2 ** CODE_W) + 1;
  localparam int MAX_A     = (MAX_PHASE > SETUP_CAP) ? MAX_PHASE : SETUP_CAP;
  localparam int MAX_LEN   = (MAX_A > STAB_CYCLES) ? MAX_A : STAB_CYCLES;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  logic trg_hit;

  adc_trig_sync #(
    .LAT(TRIG_LAT)
  ) u_trig (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .hw_mode  (hw_mode),
    .src_sel  (src_sel),
    .sw_trig  (sw_trig),
    .ext_trig (ext_trig),
    .tmr_trig (tmr_trig),
    .trg_hit  (trg_hit)
  );

  adc_seq_fsm #(
    .CODE_W      (CODE_W),
    .STAB_CYCLES (STAB_CYCLES),
    .SETUP_UNIT  (SETUP_UNIT),
    .SETUP_CAP   (SETUP_CAP),
    .CONV_UNIT   (CONV_UNIT),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .cfg_wr   (cfg_wr),
    .trg_hit  (trg_hit),
    .speed    (speed),
    .ph_stab  (ph_stab),
    .ph_setup (ph_setup),
    .ph_conv  (ph_conv),
    .ph_wait  (ph_wait),
    .conv_en  (conv_en),
    .eoc      (eoc)
  );

endmodule

// File: tb/adc_conv_sequencer_bench.sv
module adc_conv_sequencer_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, hw_mode = 1'b0, src_sel = 1'b0;
  logic sw_trig = 1'b0, ext_trig = 1'b0, tmr_trig = 1'b0, cfg_wr = 1'b0;
  logic [2:0] speed = 3'd0;
  logic ph_stab, ph_setup, ph_conv, ph_wait, conv_en, eoc;

  adc_conv_sequencer u_adc_conv_sequencer (
    .clk(clk), .rst(rst), .en(en), .hw_mode(hw_mode), .src_sel(src_sel),
    .sw_trig(sw_trig), .ext_trig(ext_trig), .tmr_trig(tmr_trig),
    .cfg_wr(cfg_wr), .speed(speed),
    .ph_stab(ph_stab), .ph_setup(ph_setup), .ph_conv(ph_conv),
    .ph_wait(ph_wait), .conv_en(conv_en), .eoc(eoc)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    edge_no;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int ecnt = 0;
  int n_chk = 0, n_bad = 0;
  int c_stab = 0, c_setup = 0, c_conv = 0, c_wait = 0, c_mis = 0;
  bit done = 1'b0;
  bit eoc_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    ecnt++;
    #2;
    if (!rst) begin
      c_stab  += int'(ph_stab);
      c_setup += int'(ph_setup);
      c_conv  += int'(ph_conv);
      c_wait  += int'(ph_wait);
      if (conv_en != ph_conv) c_mis++;
      if (eoc && eoc_prev) chk(1'b0, "R5 eoc width", 2, 1);
      if (eoc) begin
        if (sbq.size() == 0) chk(1'b0, "R5 unexpected eoc", ecnt, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(ecnt == e.edge_no, e.tag, ecnt, e.edge_no);
        end
      end
      eoc_prev = eoc;
    end
  end

  function automatic int s_len(input int c);
    return (13 * (c + 1) > 50) ? 50 : 13 * (c + 1);
  endfunction
  function automatic int total(input int c);
    return s_len(c) + 26 * (c + 1) + 26 * (c + 1) + 1;
  endfunction

  task automatic clr_cnt();
    c_stab = 0; c_setup = 0; c_conv = 0; c_wait = 0; c_mis = 0;
  endtask

  task automatic push(input int edge_no, input string tag);
    exp_t e;
    e.edge_no = edge_no;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // which: 0 sw, 1 ext, 2 tmr, 3 cfg write
  task automatic pulse(input int which, output int k);
    @(negedge clk);
    case (which)
      0: sw_trig = 1'b1;
      1: ext_trig = 1'b1;
      2: tmr_trig = 1'b1;
      default: cfg_wr = 1'b1;
    endcase
    k = ecnt + 1;
    @(negedge clk);
    sw_trig = 1'b0; ext_trig = 1'b0; tmr_trig = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic wait_q();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic until_edge(input int e);
    while (ecnt < e) @(negedge clk);
  endtask

  task automatic enable_fresh(output int e0);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    e0 = ecnt + 1;
    clr_cnt();
  endtask

  initial begin
    int k, e0;
    repeat (4) @(negedge clk);
    chk({ph_stab, ph_setup, ph_conv, ph_wait, conv_en, eoc} == 6'b0, "R1 reset state",
        int'({ph_stab, ph_setup, ph_conv, ph_wait, conv_en, eoc}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: stabilization after enable
    en = 1'b1;
    e0 = ecnt + 1;
    clr_cnt();
    until_edge(e0 + 70);
    chk(c_stab == 64, "R2 stab length", c_stab, 64);
    chk(c_setup == 0, "R2 no setup during stab", c_setup, 0);

    // R3 R4 R5 R6: every speed code
    for (int c = 0; c < 8; c++) begin
      speed = 3'(c);
      clr_cnt();
      pulse(0, k);
      push(k + 3 + total(c), "R6 trigger to eoc");
      wait_q();
      chk(c_setup == s_len(c), "R3 setup length", c_setup, s_len(c));
      chk(c_conv == 26 * (c + 1), "R3 conv length", c_conv, 26 * (c + 1));
      chk(c_wait == 26 * (c + 1) + 1, "R3 wait length", c_wait, 26 * (c + 1) + 1);
      chk(c_mis == 0, "R4 conv_en vs ph_conv", c_mis, 0);
    end

    // R7: trigger source selection
    speed = 3'd0;
    hw_mode = 1'b1; src_sel = 1'b0;
    clr_cnt(); pulse(0, k); pulse(2, k); repeat (10) @(negedge clk);
    chk(c_setup == 0, "R7 sw/timer ignored in ext mode", c_setup, 0);
    pulse(1, k); push(k + 3 + 66, "R7 ext start"); wait_q();
    src_sel = 1'b1;
    clr_cnt(); pulse(0, k); pulse(1, k); repeat (10) @(negedge clk);
    chk(c_setup == 0, "R7 sw/ext ignored in timer mode", c_setup, 0);
    pulse(2, k); push(k + 3 + 66, "R7 timer start"); wait_q();
    hw_mode = 1'b0;
    clr_cnt(); pulse(1, k); pulse(2, k); repeat (10) @(negedge clk);
    chk(c_setup == 0, "R7 hw ignored in sw mode", c_setup, 0);

    // R11: write in ready
    clr_cnt(); pulse(3, k); repeat (10) @(negedge clk);
    chk(c_setup + c_stab == 0, "R11 write in ready", c_setup + c_stab, 0);

    // R8: write during conversion restarts with new code
    pulse(0, k);
    repeat (40) @(negedge clk);
    speed = 3'd2;
    pulse(3, k);
    push(k + total(2), "R8 write restart");
    wait_q();
    // R8: trigger during conversion restarts
    speed = 3'd1;
    pulse(0, k);
    repeat (100) @(negedge clk);
    pulse(0, k);
    push(k + 3 + total(1), "R8 trigger restart");
    wait_q();

    // R1: disable during wait suppresses eoc
    speed = 3'd0;
    pulse(0, k);
    until_edge(k + 3 + 13 + 26 + 5);
    en = 1'b0;
    @(negedge clk);
    chk({ph_stab, ph_setup, ph_conv, ph_wait, conv_en, eoc} == 6'b0, "R1 disable idles",
        int'({ph_stab, ph_setup, ph_conv, ph_wait, conv_en, eoc}), 0);
    repeat (80) @(negedge clk);

    // R9: writes on the stabilization-end edge, twice
    enable_fresh(e0);
    until_edge(e0 + 63); cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
    until_edge(e0 + 127); cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
    until_edge(e0 + 200);
    chk(c_stab == 192, "R9 repeated reinsertion", c_stab, 192);
    chk(c_setup == 0, "R9 write starts nothing", c_setup, 0);

    // R9: trigger recognised on the stabilization-end edge
    enable_fresh(e0);
    until_edge(e0 + 60); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    push(e0 + 128 + 66, "R9 trigger conflict eoc");
    wait_q();
    chk(c_stab == 128, "R9 trigger reinsertion", c_stab, 128);

    // R10: trigger held during stabilization
    enable_fresh(e0);
    until_edge(e0 + 9); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    push(e0 + 64 + 66, "R10 held trigger eoc");
    wait_q();
    chk(c_stab == 64, "R10 single stab", c_stab, 64);
    clr_cnt();
    pulse(0, k);
    push(k + 3 + 66, "R10 ready trigger eoc");
    wait_q();
    chk(c_stab == 0, "R10 no stab from ready", c_stab, 0);

    repeat (5) @(negedge clk);
    while (sbq.size() != 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(1'b0, e.tag, 0, e.edge_no);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule